// File: doc/BRIEF.md
# Warp Hit-Ratio Classifier

This block watches the stream of cache lookups made on behalf of each warp and sorts every warp into one of five divergence classes by how often its lookups hit. Each warp has a pair of saturating counters, one for lookups and one for hits. A free-running interval timer splits time into fixed sampling windows. In the last cycle of each window, every warp's class is recomputed from its counters and the counters restart. Because the profile is rebuilt from scratch in every window, the classes follow changes of program phase.

Downstream cache-insertion and memory-scheduling logic reads the class of any warp through a purely combinational lookup port. The classes are ordered by priority, and a lower code means a higher priority. A warp that made no lookups in a window keeps the class it already had. The timer is a two-state machine. It sits in PROFILE while it counts the cycles of a window. It moves PROFILE -> LATCH when the count reaches the window's second-to-last cycle. It spends exactly one cycle in LATCH, where the classes are captured and the counters are cleared, and then moves LATCH -> PROFILE.

Top module: `warp_type_classifier`

## Requirements
- R1: While reset is active, and after it is released, every warp reads as class 2 (balanced) until the first window closes.
- R2: Class codes are 0 all-hit, 1 mostly-hit, 2 balanced, 3 mostly-miss, 4 all-miss, with a lower code meaning a higher priority. The output never shows a value above 4.
- R3: A cycle with `acc_valid` high adds one to the lookup count of warp `acc_warp` only. When `acc_hit` is also high, it adds one to that warp's hit count as well.
- R4: Windows are `INTERVAL` cycles long. The clock edge numbered INTERVAL-1 after reset release (counting from 0) closes the first window, and every INTERVAL edges after that closes the next. A new class becomes visible after the closing edge, and a warp's class does not change at any other time.
- R5: When a window closes with at least one lookup, the warp is class 0 if it had no misses and class 4 if it had no hits.
- R6: Otherwise, with hits h and lookups a, the class is 1 when h*10 >= 7*a, 3 when h*10 <= 2*a, and 2 in every other case. The comparisons are done exactly in integer arithmetic.
- R7: A warp with zero lookups in a window keeps its previous class.
- R8: Both counters clear on the closing edge. A lookup presented on the closing edge is counted in the new window and is not used in the class being captured.
- R9: Once a warp's lookup count reaches 2^CNT_W-1, all further lookups from that warp in the same window are ignored, so the counted hit ratio stays as it was.
- R10: A lookup index at or above `NUM_WARPS` returns class 2.
- R11: `lkp_type` follows `lkp_warp` combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A cache lookup event is present |
| acc_warp | input | WID_W | Warp that made the lookup |
| acc_hit | input | 1 | The lookup hit |
| lkp_warp | input | WID_W | Warp whose class is requested |
| lkp_type | output | 3 | Current class of `lkp_warp` |

## Verification
The closing edge of a window and an incoming lookup can occur in the same cycle. The counters must then restart from that lookup rather than from zero, and the class being captured must leave it out. The bench provokes this by giving one warp nothing but misses during a window and then sending a single hit on that window's closing edge. It expects all-miss after that edge, and all-hit after the following window closes with no further traffic. Saturation and window closing are also combined: a warp drives its counter to the limit and then keeps sending lookups of the opposite kind, and the captured class must match the ratio at the moment of saturation.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    typedef enum logic [2:0] {
        WT_ALL_HIT     = 3'd0,
        WT_MOSTLY_HIT  = 3'd1,
        WT_BALANCED    = 3'd2,
        WT_MOSTLY_MISS = 3'd3,
        WT_ALL_MISS    = 3'd4
    } warp_type_e;

    typedef enum logic {
        PH_PROFILE = 1'b0,
        PH_LATCH   = 1'b1
    } phase_e;

endpackage

// File: rtl/wtc_interval_fsm.sv
module wtc_interval_fsm
    import wtc_pkg::*;
#(
    parameter int INTERVAL = 100000,
    localparam int TW = $clog2(INTERVAL)
) (
    input  logic clk,
    input  logic rst_n,
    output logic latch_now
);

    localparam logic [TW-1:0] LAST_TICK = TW'(INTERVAL - 2);

    phase_e         state_q;
    phase_e         state_d;
    logic [TW-1:0]  tick_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_PROFILE;
        end else begin
            state_q <= state_d;
        end
    end

    // cycle counter inside a window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else begin
            unique case (state_q)
                PH_PROFILE: tick_q <= tick_q + 1'b1;
                PH_LATCH:   tick_q <= '0;
                default:    tick_q <= '0;
            endcase
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_PROFILE: if (tick_q == LAST_TICK) state_d = PH_LATCH;
            PH_LATCH:   state_d = PH_PROFILE;
            default:    state_d = PH_PROFILE;
        endcase
    end

    // outputs
    always_comb begin
        latch_now = (state_q == PH_LATCH);
    end

endmodule

// File: rtl/wtc_warp_counters.sv
module wtc_warp_counters #(
    parameter int NUM_WARPS = 48,
    parameter int CNT_W     = 16,
    parameter int WID_W     = 6
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                latch_now,
    input  logic                                acc_valid,
    input  logic [WID_W-1:0]                    acc_warp,
    input  logic                                acc_hit,
    output logic [NUM_WARPS-1:0][CNT_W-1:0]     acc_cnt,
    output logic [NUM_WARPS-1:0][CNT_W-1:0]     hit_cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    for (genvar g = 0; g < NUM_WARPS; g++) begin : g_warp
        logic             sel;
        logic             full;
        logic [CNT_W-1:0] acc_q;
        logic [CNT_W-1:0] hit_q;

        assign sel  = acc_valid && (acc_warp == WID_W'(g));
        assign full = (acc_q == CNT_MAX);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q <= '0;
                hit_q <= '0;
            end else if (latch_now) begin
                // the new window starts with the event that lands on the closing edge
                acc_q <= sel ? CNT_ONE : '0;
                hit_q <= (sel && acc_hit) ? CNT_ONE : '0;
            end else if (sel && !full) begin
                acc_q <= acc_q + 1'b1;
                hit_q <= hit_q + CNT_W'(acc_hit);
            end
        end

        assign acc_cnt[g] = acc_q;
        assign hit_cnt[g] = hit_q;
    end

endmodule

// File: rtl/wtc_type_table.sv
module wtc_type_table
    import wtc_pkg::*;
#(
    parameter int NUM_WARPS = 48,
    parameter int CNT_W     = 16,
    parameter int WID_W     = 6,
    parameter int HIT_NUM   = 7,
    parameter int MISS_NUM  = 2,
    parameter int RATIO_DEN = 10
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                latch_now,
    input  logic [NUM_WARPS-1:0][CNT_W-1:0]     acc_cnt,
    input  logic [NUM_WARPS-1:0][CNT_W-1:0]     hit_cnt,
    input  logic [WID_W-1:0]                    lkp_warp,
    output logic [2:0]                          lkp_type
);

    localparam int PW = CNT_W + 8;

    logic [NUM_WARPS-1:0][2:0] type_vec;

    for (genvar g = 0; g < NUM_WARPS; g++) begin : g_warp
        warp_type_e     type_q;
        warp_type_e     type_d;
        logic [PW-1:0]  hit_scaled;
        logic [PW-1:0]  acc_hi;
        logic [PW-1:0]  acc_lo;

        assign hit_scaled = PW'(hit_cnt[g]) * PW'(RATIO_DEN);
        assign acc_hi     = PW'(acc_cnt[g]) * PW'(HIT_NUM);
        assign acc_lo     = PW'(acc_cnt[g]) * PW'(MISS_NUM);

        always_comb begin
            type_d = type_q;
            if (acc_cnt[g] == '0) begin
                type_d = type_q;
            end else if (hit_cnt[g] == acc_cnt[g]) begin
                type_d = WT_ALL_HIT;
            end else if (hit_cnt[g] == '0) begin
                type_d = WT_ALL_MISS;
            end else if (hit_scaled >= acc_hi) begin
                type_d = WT_MOSTLY_HIT;
            end else if (hit_scaled <= acc_lo) begin
                type_d = WT_MOSTLY_MISS;
            end else begin
                type_d = WT_BALANCED;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                type_q <= WT_BALANCED;
            end else if (latch_now) begin
                type_q <= type_d;
            end
        end

        assign type_vec[g] = type_q;
    end

    logic in_range;
    assign in_range = ({1'b0, lkp_warp} < (WID_W+1)'(NUM_WARPS));

    always_comb begin
        if (in_range) begin
            lkp_type = type_vec[lkp_warp];
        end else begin
            lkp_type = WT_BALANCED;
        end
    end

endmodule

// File: rtl/warp_type_classifier.sv
module warp_type_classifier #(
    parameter int NUM_WARPS = 48,
    parameter int CNT_W     = 16,
    parameter int INTERVAL  = 100000,
    parameter int HIT_NUM   = 7,
    parameter int MISS_NUM  = 2,
    parameter int RATIO_DEN = 10,
    localparam int WID_W    = $clog2(NUM_WARPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [WID_W-1:0] acc_warp,
    input  logic             acc_hit,
    input  logic [WID_W-1:0] lkp_warp,
    output logic [2:0]       lkp_type
);

    logic                            latch_now;
    logic [NUM_WARPS-1:0][CNT_W-1:0] acc_cnt;
    logic [NUM_WARPS-1:0][CNT_W-1:0] hit_cnt;

    wtc_interval_fsm #(
        .INTERVAL (INTERVAL)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_now (latch_now)
    );

    wtc_warp_counters #(
        .NUM_WARPS (NUM_WARPS),
        .CNT_W     (CNT_W),
        .WID_W     (WID_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_now (latch_now),
        .acc_valid (acc_valid),
        .acc_warp  (acc_warp),
        .acc_hit   (acc_hit),
        .acc_cnt   (acc_cnt),
        .hit_cnt   (hit_cnt)
    );

    wtc_type_table #(
        .NUM_WARPS (NUM_WARPS),
        .CNT_W     (CNT_W),
        .WID_W     (WID_W),
        .HIT_NUM   (HIT_NUM),
        .MISS_NUM  (MISS_NUM),
        .RATIO_DEN (RATIO_DEN)
    ) u_tab (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_now (latch_now),
        .acc_cnt   (acc_cnt),
        .hit_cnt   (hit_cnt),
        .lkp_warp  (lkp_warp),
        .lkp_type  (lkp_type)
    );

endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
    parameter int NUM_WARPS = 48,
    parameter int INTERVAL  = 100000,
    parameter int WID_W     = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             latch_now,
    input logic [WID_W-1:0] lkp_warp,
    input logic [2:0]       lkp_type
);

    localparam int GW = $clog2(INTERVAL) + 1;

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (latch_now) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assert_type_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_type <= 3'd4);

    assert_type_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(latch_now) && $stable(lkp_warp)) |-> $stable(lkp_type));

    assert_window_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        latch_now == (gap_q == GW'(INTERVAL - 1)));

    assert_oob_balanced_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, lkp_warp} >= (WID_W+1)'(NUM_WARPS)) |-> (lkp_type == 3'd2));

endmodule

bind warp_type_classifier wtc_checker #(
    .NUM_WARPS (NUM_WARPS),
    .INTERVAL  (INTERVAL),
    .WID_W     (WID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .latch_now (latch_now),
    .lkp_warp  (lkp_warp),
    .lkp_type  (lkp_type)
);

// File: tb/tb_warp_type_classifier.sv
module tb_warp_type_classifier;

    localparam int CLK_PERIOD = 10;
    localparam int N    = 6;
    localparam int CW   = 4;
    localparam int IV   = 128;
    localparam int WW   = 3;
    localparam int MAXC = 15;

    logic          clk;
    logic          rst_n;
    logic          acc_valid;
    logic [WW-1:0] acc_warp;
    logic          acc_hit;
    logic [WW-1:0] lkp_warp;
    logic [2:0]    lkp_type;

    int checks = 0;
    int errors = 0;
    int edges  = 0;
    int m_acc  [N];
    int m_hit  [N];
    int m_type [N];

    warp_type_classifier #(
        .NUM_WARPS (N),
        .CNT_W     (CW),
        .INTERVAL  (IV)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_warp  (acc_warp),
        .acc_hit   (acc_hit),
        .lkp_warp  (lkp_warp),
        .lkp_type  (lkp_type)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // class rules of R5, R6, R7
    function automatic int classify(int a, int h, int prev);
        if (a == 0) return prev;
        if (h == a) return 0;
        if (h == 0) return 4;
        if (h * 10 >= 7 * a) return 1;
        if (h * 10 <= 2 * a) return 3;
        return 2;
    endfunction

    // one clock edge; inputs set after a falling edge
    task automatic apply_edge(input bit v, input int w, input bit hit);
        bit closing;
        acc_valid = v;
        acc_warp  = WW'(w);
        acc_hit   = hit;
        closing   = ((edges % IV) == IV - 1);
        if (closing) begin
            for (int k = 0; k < N; k++) begin
                m_type[k] = classify(m_acc[k], m_hit[k], m_type[k]);
                m_acc[k]  = 0;
                m_hit[k]  = 0;
            end
        end
        if (v && (m_acc[w] < MAXC)) begin   // R9 saturation
            m_acc[w]++;
            if (hit) m_hit[w]++;
        end
        @(posedge clk);
        edges++;
        @(negedge clk);
        acc_valid = 1'b0;
        acc_hit   = 1'b0;
    endtask

    task automatic finish_window();
        do apply_edge(1'b0, 0, 1'b0); while ((edges % IV) != 0);
    endtask

    task automatic check_type(input int w, input int exp, input string req);
        lkp_warp = WW'(w);
        #1;                                // R11: no clock needed
        checks++;
        if (lkp_type !== 3'(exp)) begin
            errors++;
            $display("FAIL %s warp %0d: got %0d expected %0d", req, w, lkp_type, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int k = 0; k < N; k++) check_type(k, m_type[k], req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; acc_valid = 1'b0; acc_warp = '0; acc_hit = 1'b0; lkp_warp = '0;
        for (int k = 0; k < N; k++) begin m_acc[k] = 0; m_hit[k] = 0; m_type[k] = 2; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;
        edges = 0;
        check_all("R1 after release");
        check_type(6, 2, "R10 out of range");
        check_type(7, 2, "R10 out of range");

        // R3 R5 R6 R7: sweep every (hits, misses) pair in 0..7, one pair per warp per window
        for (int base = 0; base < 64; base += N) begin
            for (int k = 0; k < N; k++) begin
                int p = base + k;
                if (p < 64) begin
                    for (int i = 0; i < p / 8; i++) apply_edge(1'b1, k, 1'b1);
                    for (int i = 0; i < p % 8; i++) apply_edge(1'b1, k, 1'b0);
                end
            end
            check_all("R4 held mid-window");
            finish_window();
            check_all("R5/R6/R7 sweep");
        end
        check_type(7, 2, "R10 out of range after sweep");

        // R9: saturation freezes the ratio
        for (int i = 0; i < 12; i++) apply_edge(1'b1, 0, 1'b1);
        for (int i = 0; i < 8;  i++) apply_edge(1'b1, 0, 1'b0);
        for (int i = 0; i < 14; i++) apply_edge(1'b1, 1, 1'b0);
        for (int i = 0; i < 6;  i++) apply_edge(1'b1, 1, 1'b1);
        finish_window();
        check_type(0, 1, "R9 saturated mostly-hit");
        check_type(1, 3, "R9 saturated mostly-miss");
        check_all("R9 all warps");

        // R8: lookup on the closing edge belongs to the next window
        for (int i = 0; i < 3; i++) apply_edge(1'b1, 2, 1'b0);
        while ((edges % IV) != IV - 1) apply_edge(1'b0, 0, 1'b0);
        apply_edge(1'b1, 2, 1'b1);
        check_type(2, 4, "R8 closing-edge hit excluded");
        finish_window();
        check_type(2, 0, "R8 closing-edge hit counted next");
        check_type(0, 1, "R7 idle window keeps class");
        check_all("R8 all warps");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule